// File: doc/BRIEF.md
# Tachometer Timer Register and Interrupt Interface

This block is the software-visible face of a two-channel tachometer timer. It decodes a small bus with mixed byte and halfword registers, and it drops any access whose size does not fit the register addressed. It holds the configuration fields that steer the two capture channels and drives them out as separate pins. It also keeps the count and capture values that the channels load, so the bus can read them.

Six one-cycle event pulses come from the channels: a capture, an underflow and a compare hit for each of the two channels. Each pulse latches a pending flag. A separate write-only register clears pending flags by writing ones to them. An enable mask selects which pending flags reach the single registered interrupt line. The counting logic of the channels is outside this block.

Top module: `tach_regif`

## Requirements
- R1: These registers accept only halfword accesses (`bus_half`=1) at the offsets shown: count A 0x00, capture A 0x02, capture B 0x04, count B 0x06, target A 0x14, target B 0x16. Target A and target B are read/write. The count and capture registers accept writes without error, but the writes have no effect.
- R2: These registers accept only byte accesses (`bus_half`=0), with the data on bits 7:0 and read bits 15:8 returned as 0: prescale 0x08, clock select 0x0A, mode 0x0C, pending 0x0E, clear 0x10, enable 0x12, compare config 0x18, input select A 0x1A, input select B 0x1C.
- R3: Some accesses are illegal: an odd address, an address not listed in R1 or R2, or a size that does not match the register. An illegal access returns `bus_err`=1 with `bus_rdata`=0 and changes no register.
- R4: Each access is sampled on the clock edge where `bus_valid` is 1. A write takes effect at that edge. `bus_rdata` and `bus_err` are registered and hold the result during the following cycle. Writes, and cycles with no access, return 0.
- R5: The pending register keeps its bits in this order: bit0 capture A, bit1 capture B, bit2 underflow A, bit3 underflow B, bit4 compare hit A, bit5 compare hit B. An event pulse sets its bit at the edge where the pulse is sampled. Bus writes to the pending register have no effect.
- R6: A write to the clear register clears every pending bit whose write-data bit is 1. A read of the clear register returns 0.
- R7: When an event and a clear for the same pending bit fall in the same cycle, the bit ends up set.
- R8: The enable register uses the bit layout of R5. `irq` is a register that, one edge after the pending state, shows the OR over all bits of (pending AND enable).
- R9: Mode register fields: bit6 enable B, bit5 enable A, bit4 edge B, bit3 edge A, bit2 mode 5. Clock select fields: bit0 channel A, bit3 channel B. Compare config fields: bits 3:0 drive channel A, bits 7:4 drive channel B. The input select registers use bit0. Bits outside these fields read back as 0.
- R10: Reset clears every register from prescale through input select B, including both targets, and it also clears the interrupt. The count and capture registers keep their contents through reset.
- R11: Each count and capture register loads its channel value on the edge where its load strobe is 1, and the bus can read it from the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | Registered illegal-access flag |
| cnt_a_load | input | 1 | Load strobe for count A |
| cnt_a_in | input | 16 | Count A value |
| cap_a_load | input | 1 | Load strobe for capture A |
| cap_a_in | input | 16 | Capture A value |
| cnt_b_load | input | 1 | Load strobe for count B |
| cnt_b_in | input | 16 | Count B value |
| cap_b_load | input | 1 | Load strobe for capture B |
| cap_b_in | input | 16 | Capture B value |
| evt | input | 6 | Event pulses, laid out as in R5 |
| prescale | output | 8 | Prescale value |
| clk_sel_a | output | 1 | Clock select, channel A |
| clk_sel_b | output | 1 | Clock select, channel B |
| ch_en_a | output | 1 | Channel A enable |
| ch_en_b | output | 1 | Channel B enable |
| edge_a | output | 1 | Channel A edge select |
| edge_b | output | 1 | Channel B edge select |
| mode5 | output | 1 | Mode 5 select |
| cmp_cfg_a | output | 4 | Compare config, channel A |
| cmp_cfg_b | output | 4 | Compare config, channel B |
| in_sel_a | output | 1 | Input select, channel A |
| in_sel_b | output | 1 | Input select, channel B |
| target_a | output | 16 | Compare target A |
| target_b | output | 16 | Compare target B |
| irq | output | 1 | Interrupt |

## Verification
Read data and the error flag are due in the cycle after the access edge. The driver stamps each expected response with the cycle in which it issued the access. The monitor pops an item only once the cycle counter has moved past that stamp, and it samples on the falling edge. Configuration pins and pending state change at the access or event edge. The interrupt changes one edge later, so irq checks wait one extra falling edge after the pending change.

// File: rtl/tach_regif_pkg.sv
package tach_regif_pkg;
   // register index = byte address / 2
   typedef enum logic [3:0] {
      RG_CNT_A   = 4'd0,
      RG_CAP_A   = 4'd1,
      RG_CAP_B   = 4'd2,
      RG_CNT_B   = 4'd3,
      RG_PRESC   = 4'd4,
      RG_CLKSEL  = 4'd5,
      RG_MODE    = 4'd6,
      RG_PEND    = 4'd7,
      RG_CLR     = 4'd8,
      RG_IEN     = 4'd9,
      RG_TGT_A   = 4'd10,
      RG_TGT_B   = 4'd11,
      RG_CMPCFG  = 4'd12,
      RG_INSEL_A = 4'd13,
      RG_INSEL_B = 4'd14,
      RG_NONE    = 4'd15
   } reg_e;

   function automatic logic is_half(reg_e r);
      return (r == RG_CNT_A) || (r == RG_CAP_A) || (r == RG_CAP_B) ||
             (r == RG_CNT_B) || (r == RG_TGT_A) || (r == RG_TGT_B);
   endfunction
endpackage

// File: rtl/tach_addr_decode.sv
module tach_addr_decode
   import tach_regif_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              size_half,
   output reg_e              sel,
   output logic              legal
);
   logic upper_zero;

   generate
      if (ADDR_W < 5) begin : g_bad_width
         $error("tach_addr_decode: ADDR_W must be at least 5");
      end
      if (ADDR_W > 5) begin : g_wide
         assign upper_zero = (addr[ADDR_W-1:5] == '0);
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      sel   = reg_e'(addr[4:1]);
      legal = upper_zero && !addr[0] && (sel != RG_NONE) &&
              (is_half(sel) == size_half);
   end
endmodule

// File: rtl/tach_hold_reg.sv
module tach_hold_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   // no reset: value survives block reset
   always_ff @(posedge clk) begin
      if (load) q <= din;
   end
endmodule

// File: rtl/tach_irq_ctrl.sv
module tach_irq_ctrl #(
   parameter int N_EVT   = 6,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt,
   input  logic [N_EVT-1:0] clr_mask,
   input  logic [N_EVT-1:0] ien,
   output logic [N_EVT-1:0] pend,
   output logic             irq
);
   logic active;

   generate
      for (genvar k = 0; k < N_EVT; k++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           bit_q <= 1'b0;
            else if (evt[k])      bit_q <= 1'b1;   // set beats clear
            else if (clr_mask[k]) bit_q <= 1'b0;
         end
         assign pend[k] = bit_q;
      end
   endgenerate

   assign active = |(pend & ien);

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= active;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = active;
      end
   endgenerate
endmodule

// File: rtl/tach_regif.sv
module tach_regif
   import tach_regif_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int HALF_W  = 16,
   parameter int BYTE_W  = 8,
   parameter int N_EVT   = 6,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic              bus_half,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              bus_err,
   input  logic              cnt_a_load,
   input  logic [15:0]       cnt_a_in,
   input  logic              cap_a_load,
   input  logic [15:0]       cap_a_in,
   input  logic              cnt_b_load,
   input  logic [15:0]       cnt_b_in,
   input  logic              cap_b_load,
   input  logic [15:0]       cap_b_in,
   input  logic [5:0]        evt,
   output logic [7:0]        prescale,
   output logic              clk_sel_a,
   output logic              clk_sel_b,
   output logic              ch_en_a,
   output logic              ch_en_b,
   output logic              edge_a,
   output logic              edge_b,
   output logic              mode5,
   output logic [3:0]        cmp_cfg_a,
   output logic [3:0]        cmp_cfg_b,
   output logic              in_sel_a,
   output logic              in_sel_b,
   output logic [15:0]       target_a,
   output logic [15:0]       target_b,
   output logic              irq
);
   localparam int N_HOLD = 4;
   localparam int PAD_E  = HALF_W - N_EVT;

   generate
      if (HALF_W != 16 || BYTE_W != 8) begin : g_bad_data
         $error("tach_regif: data widths are fixed at 16/8");
      end
      if (N_EVT != 6) begin : g_bad_evt
         $error("tach_regif: six event sources expected");
      end
   endgenerate

   reg_e        sel;
   logic        legal;
   logic        wr_ok;
   logic [4:0]  mode_q;     // bits 6:2
   logic        ck_a_q, ck_b_q;
   logic [7:0]  presc_q, cmpcfg_q;
   logic        insel_a_q, insel_b_q;
   logic [N_EVT-1:0] ien_q, pend_q, clr_mask;
   logic [15:0] tgt_a_q, tgt_b_q;
   logic [15:0] rd_mux;
   logic [N_HOLD-1:0] hold_ld;
   logic [15:0] hold_din [N_HOLD];
   logic [15:0] hold_q   [N_HOLD];

   tach_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr      (bus_addr),
      .size_half (bus_half),
      .sel       (sel),
      .legal     (legal)
   );

   assign wr_ok = bus_valid && bus_write && legal;

   // count/capture holding registers, order: cnt A, cap A, cap B, cnt B
   assign hold_ld     = {cnt_b_load, cap_b_load, cap_a_load, cnt_a_load};
   assign hold_din[0] = cnt_a_in;
   assign hold_din[1] = cap_a_in;
   assign hold_din[2] = cap_b_in;
   assign hold_din[3] = cnt_b_in;

   generate
      for (genvar h = 0; h < N_HOLD; h++) begin : g_hold
         tach_hold_reg #(.W(HALF_W)) u_hold (
            .clk  (clk),
            .load (hold_ld[h]),
            .din  (hold_din[h]),
            .q    (hold_q[h])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q   <= '0;
         ck_a_q    <= 1'b0;
         ck_b_q    <= 1'b0;
         mode_q    <= '0;
         ien_q     <= '0;
         tgt_a_q   <= '0;
         tgt_b_q   <= '0;
         cmpcfg_q  <= '0;
         insel_a_q <= 1'b0;
         insel_b_q <= 1'b0;
      end else if (wr_ok) begin
         case (sel)
            RG_PRESC:   presc_q   <= bus_wdata[7:0];
            RG_CLKSEL:  begin
               ck_a_q <= bus_wdata[0];
               ck_b_q <= bus_wdata[3];
            end
            RG_MODE:    mode_q    <= bus_wdata[6:2];
            RG_IEN:     ien_q     <= bus_wdata[N_EVT-1:0];
            RG_TGT_A:   tgt_a_q   <= bus_wdata;
            RG_TGT_B:   tgt_b_q   <= bus_wdata;
            RG_CMPCFG:  cmpcfg_q  <= bus_wdata[7:0];
            RG_INSEL_A: insel_a_q <= bus_wdata[0];
            RG_INSEL_B: insel_b_q <= bus_wdata[0];
            default:    ;
         endcase
      end
   end

   assign clr_mask = (wr_ok && sel == RG_CLR) ? bus_wdata[N_EVT-1:0] : '0;

   tach_irq_ctrl #(.N_EVT(N_EVT), .IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .clr_mask (clr_mask),
      .ien      (ien_q),
      .pend     (pend_q),
      .irq      (irq)
   );

   always_comb begin
      case (sel)
         RG_CNT_A:   rd_mux = hold_q[0];
         RG_CAP_A:   rd_mux = hold_q[1];
         RG_CAP_B:   rd_mux = hold_q[2];
         RG_CNT_B:   rd_mux = hold_q[3];
         RG_PRESC:   rd_mux = {8'h00, presc_q};
         RG_CLKSEL:  rd_mux = {12'h000, ck_b_q, 2'b00, ck_a_q};
         RG_MODE:    rd_mux = {9'h000, mode_q, 2'b00};
         RG_PEND:    rd_mux = {{PAD_E{1'b0}}, pend_q};
         RG_IEN:     rd_mux = {{PAD_E{1'b0}}, ien_q};
         RG_TGT_A:   rd_mux = tgt_a_q;
         RG_TGT_B:   rd_mux = tgt_b_q;
         RG_CMPCFG:  rd_mux = {8'h00, cmpcfg_q};
         RG_INSEL_A: rd_mux = {15'h0000, insel_a_q};
         RG_INSEL_B: rd_mux = {15'h0000, insel_b_q};
         default:    rd_mux = '0;   // clear register reads zero
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_err   <= bus_valid && !legal;
         bus_rdata <= (bus_valid && !bus_write && legal) ? rd_mux : '0;
      end
   end

   assign prescale  = presc_q;
   assign clk_sel_a = ck_a_q;
   assign clk_sel_b = ck_b_q;
   assign ch_en_b   = mode_q[4];
   assign ch_en_a   = mode_q[3];
   assign edge_b    = mode_q[2];
   assign edge_a    = mode_q[1];
   assign mode5     = mode_q[0];
   assign cmp_cfg_a = cmpcfg_q[3:0];
   assign cmp_cfg_b = cmpcfg_q[7:4];
   assign in_sel_a  = insel_a_q;
   assign in_sel_b  = insel_b_q;
   assign target_a  = tgt_a_q;
   assign target_b  = tgt_b_q;
endmodule

// File: rtl/tach_regif_chk.sv
module tach_regif_chk #(
   parameter int N_EVT = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_valid,
   input logic             bus_write,
   input logic             bus_err,
   input logic [15:0]      bus_rdata,
   input logic [N_EVT-1:0] evt,
   input logic [N_EVT-1:0] pend,
   input logic [N_EVT-1:0] ien,
   input logic [7:0]       prescale,
   input logic [15:0]      target_a,
   input logic             irq
);
   // R3: an error response carries zero data
   a_r3_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == 16'h0000));

   // R3: a rejected access leaves configuration untouched
   a_r3_err_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> ($stable(prescale) && $stable(target_a) && $stable(ien)));

   // R5 / R7: every sampled event leaves its pending bit set
   a_r5_evt_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

   // R6: pending bits drop only after a bus write
   a_r6_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      ((~pend & $past(pend)) != '0) |-> $past(bus_valid && bus_write));

   // R8: interrupt follows enabled pending one edge later
   a_r8_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend & ien)) |=> irq);
   a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(pend & ien)) |=> !irq);

   // R10: state right after reset release
   a_r10_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (prescale == 8'h00 && target_a == 16'h0000 &&
                        pend == '0 && !irq));
endmodule

bind tach_regif tach_regif_chk #(.N_EVT(N_EVT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_err   (bus_err),
   .bus_rdata (bus_rdata),
   .evt       (evt),
   .pend      (pend_q),
   .ien       (ien_q),
   .prescale  (prescale),
   .target_a  (target_a),
   .irq       (irq)
);

// File: tb/tach_regif_test.sv
module tach_regif_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0, bus_half = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_err;
   logic        cnt_a_load = 0, cap_a_load = 0, cnt_b_load = 0, cap_b_load = 0;
   logic [15:0] cnt_a_in = '0, cap_a_in = '0, cnt_b_in = '0, cap_b_in = '0;
   logic [5:0]  evt = '0;
   logic [7:0]  prescale;
   logic        clk_sel_a, clk_sel_b, ch_en_a, ch_en_b, edge_a, edge_b, mode5;
   logic [3:0]  cmp_cfg_a, cmp_cfg_b;
   logic        in_sel_a, in_sel_b;
   logic [15:0] target_a, target_b;
   logic        irq;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 0;

   typedef struct {
      logic [15:0] data;
      logic        err;
      int          stamp;
      string       tag;
   } exp_t;
   exp_t sb[$];

   tach_regif uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err),
      .cnt_a_load(cnt_a_load), .cnt_a_in(cnt_a_in),
      .cap_a_load(cap_a_load), .cap_a_in(cap_a_in),
      .cnt_b_load(cnt_b_load), .cnt_b_in(cnt_b_in),
      .cap_b_load(cap_b_load), .cap_b_in(cap_b_in),
      .evt(evt), .prescale(prescale), .clk_sel_a(clk_sel_a),
      .clk_sel_b(clk_sel_b), .ch_en_a(ch_en_a), .ch_en_b(ch_en_b),
      .edge_a(edge_a), .edge_b(edge_b), .mode5(mode5),
      .cmp_cfg_a(cmp_cfg_a), .cmp_cfg_b(cmp_cfg_b),
      .in_sel_a(in_sel_a), .in_sel_b(in_sel_b),
      .target_a(target_a), .target_b(target_b), .irq(irq)
   );

   always #2 clk = ~clk;   // 250 MHz
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops each response once its access edge has passed
   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].stamp < cyc) begin
         exp_t it;
         it = sb.pop_front();
         check({15'h0, bus_err}, {15'h0, it.err}, {it.tag, " err"});
         check(bus_rdata, it.data, {it.tag, " data"});
      end
   end

   // driver: one access, expected response pushed to the scoreboard
   task automatic acc(input logic wr, input logic half, input logic [4:0] addr,
                      input logic [15:0] wd, input logic [15:0] exp_d,
                      input logic exp_e, input string tag);
      exp_t it;
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_half = half;
      bus_addr = addr; bus_wdata = wd;
      it.data = exp_d; it.err = exp_e; it.stamp = cyc; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic pulse(input logic [5:0] m);
      @(negedge clk); evt = m;
      @(negedge clk); evt = '0;
   endtask

   initial begin
      #(4 * 50000);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      if (!done) begin
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check({8'h0, prescale}, 16'h0000, "R10 prescale reset");
      check({15'h0, irq}, 16'h0000, "R10 irq reset");
      acc(0, 0, 5'h0E, 0, 16'h0000, 0, "R10 pending reset");

      // R2 / R4 byte register write and readback
      acc(1, 0, 5'h08, 16'h00A5, 16'h0000, 0, "R4 write returns zero");
      check({8'h0, prescale}, 16'h00A5, "R2 prescale pin");
      acc(0, 0, 5'h08, 0, 16'h00A5, 0, "R2 prescale read");
      // R3 wrong size is rejected and has no effect
      acc(1, 1, 5'h08, 16'h1111, 16'h0000, 1, "R3 half on byte reg");
      acc(0, 0, 5'h08, 0, 16'h00A5, 0, "R3 prescale unchanged");

      // R1 target registers
      acc(1, 1, 5'h14, 16'hBEEF, 16'h0000, 0, "R1 target A write");
      acc(1, 1, 5'h16, 16'h0F0F, 16'h0000, 0, "R1 target B write");
      check(target_a, 16'hBEEF, "R1 target A pin");
      check(target_b, 16'h0F0F, "R1 target B pin");
      acc(0, 1, 5'h14, 0, 16'hBEEF, 0, "R1 target A read");
      acc(0, 0, 5'h14, 0, 16'h0000, 1, "R3 byte on half reg");
      acc(1, 0, 5'h16, 16'h0055, 16'h0000, 1, "R3 byte write target B");
      check(target_b, 16'h0F0F, "R3 target B unchanged");
      // R3 bad addresses
      acc(0, 0, 5'h09, 0, 16'h0000, 1, "R3 odd address");
      acc(0, 1, 5'h1E, 0, 16'h0000, 1, "R3 unmapped address");

      // R9 field decode
      acc(1, 0, 5'h0C, 16'h00FF, 16'h0000, 0, "R9 mode write all");
      check({9'h0, ch_en_b, ch_en_a, edge_b, edge_a, mode5, 2'b0}, 16'h007C, "R9 mode pins all");
      acc(0, 0, 5'h0C, 0, 16'h007C, 0, "R9 mode readback masked");
      acc(1, 0, 5'h0C, 16'h0028, 16'h0000, 0, "R9 mode write A");
      check({11'h0, ch_en_b, ch_en_a, edge_b, edge_a, mode5}, 16'h000A, "R9 mode pins A");
      acc(1, 0, 5'h0A, 16'h0008, 16'h0000, 0, "R9 clksel write");
      check({14'h0, clk_sel_b, clk_sel_a}, 16'h0002, "R9 clksel pins");
      acc(1, 0, 5'h18, 16'h005A, 16'h0000, 0, "R9 cmpcfg write");
      check({8'h0, cmp_cfg_b, cmp_cfg_a}, 16'h005A, "R9 cmpcfg nibbles");
      acc(1, 0, 5'h1A, 16'h0003, 16'h0000, 0, "R9 insel A write");
      check({14'h0, in_sel_b, in_sel_a}, 16'h0001, "R9 insel pins");

      // R11 channel loads, R1 read-only
      @(negedge clk);
      cnt_a_load = 1; cnt_a_in = 16'h1234; cap_b_load = 1; cap_b_in = 16'hCAFE;
      @(negedge clk);
      cnt_a_load = 0; cap_b_load = 0;
      acc(0, 1, 5'h00, 0, 16'h1234, 0, "R11 count A read");
      acc(0, 1, 5'h04, 0, 16'hCAFE, 0, "R11 capture B read");
      acc(1, 1, 5'h00, 16'h0000, 16'h0000, 0, "R1 count A write accepted");
      acc(0, 1, 5'h00, 0, 16'h1234, 0, "R1 count A read-only");

      // R5 / R8 events, pending, interrupt
      pulse(6'b000001);
      acc(0, 0, 5'h0E, 0, 16'h0001, 0, "R5 capture A pending");
      check({15'h0, irq}, 16'h0000, "R8 irq masked");
      acc(1, 0, 5'h12, 16'h0001, 16'h0000, 0, "R8 enable write");
      @(negedge clk);
      check({15'h0, irq}, 16'h0001, "R8 irq raised");
      // R6 clear
      acc(1, 0, 5'h10, 16'h0001, 16'h0000, 0, "R6 clear write");
      acc(0, 0, 5'h0E, 0, 16'h0000, 0, "R6 pending cleared");
      check({15'h0, irq}, 16'h0000, "R8 irq dropped");
      acc(0, 0, 5'h10, 0, 16'h0000, 0, "R6 clear reads zero");
      // R5 all events, pending not bus-writable
      pulse(6'b111111);
      acc(1, 0, 5'h0E, 16'h0000, 16'h0000, 0, "R5 pending write");
      acc(0, 0, 5'h0E, 0, 16'h003F, 0, "R5 pending unchanged");
      acc(1, 0, 5'h10, 16'h0030, 16'h0000, 0, "R6 partial clear");
      acc(0, 0, 5'h0E, 0, 16'h000F, 0, "R6 partial result");
      check({15'h0, irq}, 16'h0001, "R8 irq with bit0 enabled");

      // R7 set beats clear in the same cycle
      begin
         exp_t it;
         @(negedge clk);
         evt = 6'b000100;
         bus_valid = 1; bus_write = 1; bus_half = 0; bus_addr = 5'h10; bus_wdata = 16'h003F;
         it.data = 16'h0000; it.err = 0; it.stamp = cyc; it.tag = "R7 clear with event";
         sb.push_back(it);
         @(negedge clk);
         evt = '0; bus_valid = 0; bus_write = 0;
      end
      acc(0, 0, 5'h0E, 0, 16'h0004, 0, "R7 set wins");

      // R10 reset keeps count/capture, clears config
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(target_a, 16'h0000, "R10 target A cleared");
      check({8'h0, cmp_cfg_b, cmp_cfg_a}, 16'h0000, "R10 cmpcfg cleared");
      check({15'h0, in_sel_a}, 16'h0000, "R10 insel cleared");
      acc(0, 1, 5'h00, 0, 16'h1234, 0, "R10 count A kept");
      acc(0, 1, 5'h04, 0, 16'hCAFE, 0, "R10 capture B kept");
      acc(0, 0, 5'h0E, 0, 16'h0000, 0, "R10 pending cleared");
      acc(0, 0, 5'h12, 0, 16'h0000, 0, "R10 enable cleared");

      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule